// File: doc/BRIEF.md
# ISA Command Cycle Sequencer

This block times one ISA bus command at a time, counted in bus clocks. A request carries the cycle kind (memory or I/O), the direction (read or write), the data width (8 or 16 bits) and the address. The block drops the matching command strobe for as many clocks as the cycle needs and then gives a one-clock completion pulse. While the strobe is low it watches two slave responses on every rising clock. An active-low early-end input lets a fast slave cut the cycle short. A ready input lets a slow slave stretch the cycle with wait states.

Each cycle kind has its own default length and its own shortest length. For 16-bit I/O cycles the early-end input is not used. A not-ready seen in a clock always wins over an early-end seen in the same clock. Memory cycles whose address is in the first megabyte also drive a second pair of memory strobes. Each of these copies its parent strobe one clock later. The copies are not driven while reset is held, and they sit high once reset is released.

The request side is a valid/ready port. `req_ready` is high only when no cycle is running. A request is taken on a clock where `req_valid` and `req_ready` are both high. A requester that holds `req_valid` high waits with its fields held stable until it is taken. `req_ready` goes high again in the same clock as `cyc_done`, so cycles can run back to back.

Top module: `isa_cyc_seq`

## Requirements
- R1: While `rst` is high, all four command strobes and both low-megabyte strobes are high, `smem_oe` is 0 (the low-megabyte strobes are not driven) and `cyc_done` is 0. After release, `smem_oe` is 1 and both low-megabyte strobes are high.
- R2: `req_ready` is 1 exactly when no command strobe is low and no cycle is running. A request taken at a rising edge shows its strobe low from that edge on.
- R3: Each request drives exactly one strobe low. Memory read drives `memr_n`, memory write drives `memw_n`, I/O read drives `ior_n` and I/O write drives `iow_n`. The other three stay high.
- R4: With `zws_n` high and `iochrdy` high, 16-bit memory and 16-bit I/O strobes stay low for 3 clocks. All 8-bit strobes stay low for 6 clocks.
- R5: For a 16-bit memory cycle with `zws_n` low and `iochrdy` high, the strobe stays low for 2 clocks.
- R6: For an 8-bit memory or I/O cycle with `zws_n` low and `iochrdy` high, the strobe stays low for 3 clocks.
- R7: For a 16-bit I/O cycle, `zws_n` has no effect and the cycle lasts 3 clocks.
- R8: A cycle never ends at a clock where `iochrdy` is sampled low, even if `zws_n` is low in that clock. Once `iochrdy` is high again, the cycle ends at the first clock that meets the length rules of R4 to R6.
- R9: `smemr_n` and `smemw_n` go low only for memory cycles whose address bits [23:20] are all zero. For any other address, and for all I/O cycles, they stay high.
- R10: `smemr_n` and `smemw_n` copy `memr_n` and `memw_n` one clock later. They are low for the same number of clocks as their parent strobe.
- R11: `cyc_done` is high for one clock, in the clock right after the last clock in which the strobe was low. It is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysclk | input | 1 | Bus clock; all logic uses its rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle; the request is taken this edge |
| req_is_mem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| req_is_wr | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit cycle, 0 = 8-bit cycle |
| req_addr | input | 24 | Cycle address |
| zws_n | input | 1 | Early-end request from the slave, active low |
| iochrdy | input | 1 | Slave ready; low adds wait states |
| memr_n | output | 1 | Memory read strobe |
| memw_n | output | 1 | Memory write strobe |
| ior_n | output | 1 | I/O read strobe |
| iow_n | output | 1 | I/O write strobe |
| smemr_n | output | 1 | Low-megabyte memory read strobe |
| smemw_n | output | 1 | Low-megabyte memory write strobe |
| smem_oe | output | 1 | Drive enable for the low-megabyte strobes |
| cyc_done | output | 1 | One-clock cycle completion pulse |

## Verification
The properties assume a requester that obeys the handshake. Request fields only need to be valid on the clock where the request is taken. `zws_n` and `iochrdy` may change only between rising edges, and their values only matter while a strobe is low. The stimulus changes every input on the falling clock edge. It holds the slave responses at their idle levels outside a cycle and drops `req_valid` as soon as a request has been taken, except in the one test that runs two cycles back to back. Wait-state runs are kept short, so the saturating clock counter never reaches its limit.

// File: rtl/isa_cyc_pkg.sv
package isa_cyc_pkg;

  // Latched description of one bus command
  typedef struct packed {
    logic is_mem;   // memory (1) or I/O (0)
    logic is_wr;    // write (1) or read (0)
    logic wide;     // 16-bit (1) or 8-bit (0)
    logic low_mb;   // address inside the first megabyte
  } isa_cmd_t;

  localparam int unsigned STROBE_N = 2;  // read and write copies

endpackage

// File: rtl/isa_len_sel.sv
module isa_len_sel
  import isa_cyc_pkg::*;
#(
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned LEN_WIDE  = 3,
  parameter int unsigned LEN_NARROW = 6,
  parameter int unsigned ZW_MEM16  = 2,
  parameter int unsigned ZW_NARROW = 3
) (
  input  isa_cmd_t         cmd,
  output logic [CNT_W-1:0] full_len,
  output logic [CNT_W-1:0] short_len,
  output logic             zws_usable
);

  always_comb begin
    if (cmd.wide) begin
      full_len = CNT_W'(LEN_WIDE);
      if (cmd.is_mem) begin
        short_len  = CNT_W'(ZW_MEM16);
        zws_usable = 1'b1;
      end else begin
        // 16-bit I/O: early end is not honoured
        short_len  = CNT_W'(LEN_WIDE);
        zws_usable = 1'b0;
      end
    end else begin
      full_len   = CNT_W'(LEN_NARROW);
      short_len  = CNT_W'(ZW_NARROW);
      zws_usable = 1'b1;
    end
  end

endmodule

// File: rtl/isa_cyc_fsm.sv
module isa_cyc_fsm
  import isa_cyc_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             sysclk,
  input  logic             rst,
  input  logic             req_valid,
  input  isa_cmd_t         req_cmd,
  output logic             req_ready,
  input  logic             zws_n,
  input  logic             iochrdy,
  input  logic [CNT_W-1:0] full_len,
  input  logic [CNT_W-1:0] short_len,
  input  logic             zws_usable,
  output isa_cmd_t         cmd_q,
  output logic             cmd_on,
  output logic             done
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] clk_idx;   // index of the current command clock
  logic             reached_full;
  logic             reached_short;
  logic             finish;
  logic             take;

  assign req_ready     = !cmd_on;
  assign take          = req_valid && !cmd_on;
  assign reached_full  = (clk_idx >= full_len);
  assign reached_short = zws_usable && !zws_n && (clk_idx >= short_len);
  // not-ready always holds the cycle open
  assign finish        = cmd_on && iochrdy && (reached_full || reached_short);

  always_ff @(posedge sysclk or posedge rst) begin
    if (rst) begin
      cmd_on  <= 1'b0;
      clk_idx <= '0;
      cmd_q   <= '0;
      done    <= 1'b0;
    end else begin
      done <= finish;
      if (take) begin
        cmd_on  <= 1'b1;
        clk_idx <= CNT_W'(1);
        cmd_q   <= req_cmd;
      end else if (finish) begin
        cmd_on  <= 1'b0;
        clk_idx <= '0;
      end else if (cmd_on && (clk_idx != CNT_MAX)) begin
        clk_idx <= clk_idx + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/isa_smem_stage.sv
module isa_smem_stage
  import isa_cyc_pkg::*;
(
  input  logic                sysclk,
  input  logic                rst,
  input  logic [STROBE_N-1:0] parent_n,
  input  logic                in_low_mb,
  output logic [STROBE_N-1:0] copy_n,
  output logic                drive_en
);

  for (genvar g = 0; g < STROBE_N; g++) begin : g_copy
    logic q;
    always_ff @(posedge sysclk or posedge rst) begin
      if (rst) q <= 1'b1;
      else     q <= parent_n[g] | !in_low_mb;
    end
    assign copy_n[g] = q;
  end

  always_ff @(posedge sysclk or posedge rst) begin
    if (rst) drive_en <= 1'b0;
    else     drive_en <= 1'b1;
  end

endmodule

// File: rtl/isa_cyc_seq.sv
module isa_cyc_seq
  import isa_cyc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 24,
  parameter int unsigned LOW_MB_BITS = 20,
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned LEN_WIDE    = 3,
  parameter int unsigned LEN_NARROW  = 6,
  parameter int unsigned ZW_MEM16    = 2,
  parameter int unsigned ZW_NARROW   = 3
) (
  input  logic              sysclk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_is_mem,
  input  logic              req_is_wr,
  input  logic              req_wide,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              zws_n,
  input  logic              iochrdy,
  output logic              memr_n,
  output logic              memw_n,
  output logic              ior_n,
  output logic              iow_n,
  output logic              smemr_n,
  output logic              smemw_n,
  output logic              smem_oe,
  output logic              cyc_done
);

  localparam int unsigned HI_W = ADDR_W - LOW_MB_BITS;

  isa_cmd_t          req_cmd;
  isa_cmd_t          cmd_q;
  logic              cmd_on;
  logic [CNT_W-1:0]  full_len;
  logic [CNT_W-1:0]  short_len;
  logic              zws_usable;
  logic [STROBE_N-1:0] mem_par_n;
  logic [STROBE_N-1:0] mem_copy_n;

  always_comb begin
    req_cmd.is_mem = req_is_mem;
    req_cmd.is_wr  = req_is_wr;
    req_cmd.wide   = req_wide;
    req_cmd.low_mb = (req_addr[ADDR_W-1:LOW_MB_BITS] == HI_W'(0));
  end

  isa_len_sel #(
    .CNT_W(CNT_W), .LEN_WIDE(LEN_WIDE), .LEN_NARROW(LEN_NARROW),
    .ZW_MEM16(ZW_MEM16), .ZW_NARROW(ZW_NARROW)
  ) len_i (
    .cmd(cmd_q), .full_len(full_len), .short_len(short_len),
    .zws_usable(zws_usable)
  );

  isa_cyc_fsm #(.CNT_W(CNT_W)) fsm_i (
    .sysclk(sysclk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_ready(req_ready), .zws_n(zws_n), .iochrdy(iochrdy),
    .full_len(full_len), .short_len(short_len), .zws_usable(zws_usable),
    .cmd_q(cmd_q), .cmd_on(cmd_on), .done(cyc_done)
  );

  assign memr_n = !(cmd_on &&  cmd_q.is_mem && !cmd_q.is_wr);
  assign memw_n = !(cmd_on &&  cmd_q.is_mem &&  cmd_q.is_wr);
  assign ior_n  = !(cmd_on && !cmd_q.is_mem && !cmd_q.is_wr);
  assign iow_n  = !(cmd_on && !cmd_q.is_mem &&  cmd_q.is_wr);

  assign mem_par_n = {memw_n, memr_n};

  isa_smem_stage smem_i (
    .sysclk(sysclk), .rst(rst), .parent_n(mem_par_n),
    .in_low_mb(cmd_q.low_mb), .copy_n(mem_copy_n), .drive_en(smem_oe)
  );

  assign smemr_n = mem_copy_n[0];
  assign smemw_n = mem_copy_n[1];

endmodule

// File: rtl/isa_cyc_chk.sv
module isa_cyc_chk (
  input logic sysclk,
  input logic rst,
  input logic req_ready,
  input logic memr_n,
  input logic memw_n,
  input logic ior_n,
  input logic iow_n,
  input logic smemr_n,
  input logic smemw_n,
  input logic iochrdy,
  input logic cyc_done
);

  logic any_cmd;
  assign any_cmd = !(memr_n && memw_n && ior_n && iow_n);

  // R3
  one_strobe_chk: assert property (@(posedge sysclk) disable iff (rst)
    $onehot0(~{memr_n, memw_n, ior_n, iow_n}));

  // R2
  busy_not_ready_chk: assert property (@(posedge sysclk) disable iff (rst)
    any_cmd |-> !req_ready);

  // R8
  wait_hold_chk: assert property (@(posedge sysclk) disable iff (rst)
    (any_cmd && !iochrdy) |=> any_cmd);

  // R10
  smemr_lag_chk: assert property (@(posedge sysclk) disable iff (rst)
    !smemr_n |-> $past(!memr_n));

  // R10
  smemw_lag_chk: assert property (@(posedge sysclk) disable iff (rst)
    !smemw_n |-> $past(!memw_n));

  // R11
  done_pulse_chk: assert property (@(posedge sysclk) disable iff (rst)
    cyc_done |=> !cyc_done);

  // R11
  done_after_cmd_chk: assert property (@(posedge sysclk) disable iff (rst)
    cyc_done |-> (!any_cmd || req_ready) && $past(any_cmd));

endmodule

bind isa_cyc_seq isa_cyc_chk chk_i (
  .sysclk(sysclk), .rst(rst), .req_ready(req_ready),
  .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n),
  .smemr_n(smemr_n), .smemw_n(smemw_n), .iochrdy(iochrdy),
  .cyc_done(cyc_done)
);

// File: tb/isa_cyc_seq_tb_top.sv
`timescale 1ns/1ps
module isa_cyc_seq_tb_top;

  logic        sysclk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_is_mem = 1'b0, req_is_wr = 1'b0, req_wide = 1'b0;
  logic [23:0] req_addr = '0;
  logic        zws_n = 1'b1, iochrdy = 1'b1;
  logic        memr_n, memw_n, ior_n, iow_n, smemr_n, smemw_n, smem_oe, cyc_done;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 sysclk = ~sysclk;

  isa_cyc_seq dut_i (.*);

  // vector: mem, wide, wr, above_1m, zws, rdy_lo_start, rdy_lo_n, exp_len
  localparam logic [16:0] VEC [0:11] = '{
    {1'b1,1'b1,1'b0,1'b0,1'b0,4'd0,4'd0,4'd3},  // R4 mem16 rd
    {1'b1,1'b1,1'b0,1'b0,1'b1,4'd0,4'd0,4'd2},  // R5 mem16 rd early end
    {1'b0,1'b1,1'b0,1'b0,1'b1,4'd0,4'd0,4'd3},  // R7 io16 rd early end ignored
    {1'b0,1'b0,1'b1,1'b0,1'b1,4'd0,4'd0,4'd3},  // R6 io8 wr early end
    {1'b1,1'b0,1'b1,1'b0,1'b0,4'd0,4'd0,4'd6},  // R4 mem8 wr
    {1'b1,1'b0,1'b0,1'b1,1'b1,4'd0,4'd0,4'd3},  // R6 R9 mem8 rd above 1M
    {1'b1,1'b1,1'b0,1'b0,1'b1,4'd2,4'd1,4'd3},  // R8 not-ready beats early end
    {1'b1,1'b1,1'b0,1'b0,1'b0,4'd3,4'd3,4'd6},  // R8 wait states
    {1'b0,1'b1,1'b1,1'b0,1'b0,4'd0,4'd0,4'd3},  // R4 io16 wr
    {1'b1,1'b0,1'b0,1'b0,1'b1,4'd3,4'd2,4'd5},  // R8 mem8 early end delayed
    {1'b0,1'b0,1'b0,1'b0,1'b0,4'd0,4'd0,4'd6},  // R4 io8 rd
    {1'b1,1'b1,1'b1,1'b1,1'b1,4'd0,4'd0,4'd2}   // R5 R9 mem16 wr above 1M
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic sel_strobe(input logic mem, input logic wr);
    if (mem) return wr ? memw_n : memr_n;
    return wr ? iow_n : ior_n;
  endfunction

  task automatic run_vec(input int i);
    logic [16:0] v;
    logic mem, wide, wr, hi, zw;
    int rs, rn, exp_len, len, slen, other_low;
    bit seen_done;
    string tag;
    v = VEC[i];
    {mem, wide, wr, hi, zw} = v[16:12];
    rs = int'(v[11:8]); rn = int'(v[7:4]); exp_len = int'(v[3:0]);
    if (rn != 0) tag = "R8";
    else if (zw && wide && mem) tag = "R5";
    else if (zw && wide) tag = "R7";
    else if (zw) tag = "R6";
    else tag = "R4";
    @(negedge sysclk);
    check(req_ready == 1'b1, "R2 ready when idle", int'(req_ready), 1);
    req_is_mem = mem; req_is_wr = wr; req_wide = wide;
    req_addr = hi ? 24'h1F_0000 : 24'h0C_8000;
    req_valid = 1'b1;
    len = 0; slen = 0; other_low = 0; seen_done = 0;
    @(negedge sysclk);
    req_valid = 1'b0;
    for (int k = 1; k < 40; k++) begin
      if (sel_strobe(mem, wr) == 1'b0) begin
        len++;
        if (k == 1) check(smemr_n && smemw_n, "R10 copy lags parent", int'(smemr_n & smemw_n), 1);
        check(cyc_done == 1'b0, "R11 no done mid cycle", int'(cyc_done), 0);
        check(req_ready == 1'b0, "R2 busy", int'(req_ready), 0);
      end else begin
        check(len > 0, "R2 strobe after accept", len, 1);
        check(cyc_done == 1'b1, "R11 done after last clock", int'(cyc_done), 1);
        seen_done = 1;
      end
      if ((wr ? smemw_n : smemr_n) == 1'b0) slen++;
      if ((wr ? smemr_n : smemw_n) == 1'b0) other_low++;
      if (({memr_n, memw_n, ior_n, iow_n} == 4'b1111) == 1'b0 &&
          $countones(~{memr_n, memw_n, ior_n, iow_n}) != 1) other_low++;
      if (seen_done) break;
      zws_n   = zw ? 1'b0 : 1'b1;
      iochrdy = (rn != 0 && k >= rs && k < rs + rn) ? 1'b0 : 1'b1;
      @(negedge sysclk);
    end
    zws_n = 1'b1; iochrdy = 1'b1;
    check(len == exp_len, tag, len, exp_len);
    check(slen == ((mem && !hi) ? exp_len : 0), "R9 R10 low-megabyte strobe length",
          slen, (mem && !hi) ? exp_len : 0);
    check(other_low == 0, "R3 only the selected strobe", other_low, 0);
    @(negedge sysclk);
    check(cyc_done == 1'b0, "R11 single pulse", int'(cyc_done), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge sysclk);
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin : main
    // R1 reset state
    repeat (3) @(negedge sysclk);
    check({memr_n, memw_n, ior_n, iow_n, smemr_n, smemw_n} == 6'h3F,
          "R1 strobes high in reset", int'({memr_n, memw_n, ior_n, iow_n}), 15);
    check(smem_oe == 1'b0, "R1 not driven in reset", int'(smem_oe), 0);
    check(cyc_done == 1'b0, "R1 no done in reset", int'(cyc_done), 0);
    rst = 1'b0;
    @(negedge sysclk);
    check(smem_oe == 1'b1, "R1 driven after reset", int'(smem_oe), 1);
    check(smemr_n && smemw_n, "R1 high after reset", int'(smemr_n & smemw_n), 1);

    for (int i = 0; i < 12; i++) run_vec(i);

    // R2 R11 back to back: valid held through done
    @(negedge sysclk);
    req_is_mem = 1'b0; req_is_wr = 1'b0; req_wide = 1'b1; req_addr = 24'h000060;
    req_valid = 1'b1;
    repeat (3) begin
      @(negedge sysclk);
      check(ior_n == 1'b0, "R2 first cycle running", int'(ior_n), 0);
    end
    @(negedge sysclk);
    check(cyc_done && ior_n && req_ready, "R11 done with ready", int'(cyc_done), 1);
    @(negedge sysclk);
    req_valid = 1'b0;
    check(ior_n == 1'b0, "R2 second cycle starts", int'(ior_n), 0);
    repeat (4) @(negedge sysclk);
    check(ior_n == 1'b1 && req_ready, "R4 second cycle ended", int'(ior_n), 1);

    // R1 reset in the middle of a memory cycle
    req_is_mem = 1'b1; req_wide = 1'b0; req_addr = 24'h000100; req_valid = 1'b1;
    @(negedge sysclk);
    req_valid = 1'b0;
    @(negedge sysclk);
    check(smemr_n == 1'b0, "R10 copy low in second clock", int'(smemr_n), 0);
    #1 rst = 1'b1;
    #0.5;
    check(memr_n && smemr_n && !smem_oe, "R1 async reset clears strobes",
          int'(memr_n & smemr_n), 1);
    @(negedge sysclk);
    rst = 1'b0;
    @(negedge sysclk);
    check(memr_n && req_ready && smem_oe, "R1 idle after reset", int'(req_ready), 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule